// File: doc/BRIEF.md
# Speculative Data Cache with Consumer-Side Violation Detection

This block is a small direct-mapped data cache placed next to one core that runs a speculative thread. Each line has a tag, a valid bit, a dirty bit and one data word, plus two speculation bits. One bit records that the line was read while speculating. The other records that it was written while speculating. Speculative writes stay in the cache and never reach the backing store. A clean committed copy is written back before the first speculative write lands on a dirty line, so throwing the speculative data away later loses nothing.

Ordering between threads comes from epoch numbers. Every speculative store sends its line address and the local epoch out on a broadcast port. Other cores feed such broadcasts into this cache's invalidation port. An invalidation from a logically earlier epoch that hits a line this thread has read speculatively means the thread consumed a stale value, so the cache raises a sticky violation flag. Software or a sequencer then issues squash, which drops every speculatively written line and clears all speculation bits in one cycle. Commit clears the bits in one cycle and turns speculatively written lines into ordinary dirty lines.

Misses fill in the same cycle from a fill-data input, which carries the backing word for the requested address. A dirty victim goes out on a write-back port in the same cycle. A miss whose victim carries speculation bits is refused, and the cache raises overflow instead.

Top module: `spec_cache`

## Requirements
- R1: A load that is accepted returns its word on respData with respValid high in the cycle after the request. On a miss the line is filled from fillData. The line index is the low log2(LINES) bits of the address and the tag is the remaining upper bits.
- R2: A miss whose victim line is valid and dirty, with no speculation bits set, drives wbValid with the victim's address and data in the request cycle. A store with specMode low marks its line dirty.
- R3: A store with specMode high keeps its data in the cache only, and that data never appears on the write-back port. If the line it hits is dirty and not yet speculatively written, the old word is written back in that same cycle.
- R4: Each accepted store with specMode high drives bcastValid with bcastAddr equal to the store address and bcastEpoch equal to myEpoch in the following cycle. Plain stores and loads never drive bcastValid.
- R5: An invalidation with invEpoch lower than myEpoch (unsigned) that hits a valid line whose speculative-read bit is set raises violation in the following cycle. The speculative-read bit is set by a load with specMode high.
- R6: An invalidation with invEpoch equal to or higher than myEpoch never raises violation. Any invalidation that hits a valid line makes it invalid, so a later load of that address refills from fillData.
- R7: violation stays high through any number of cycles until squash is applied. Squash clears it in the following cycle. It is low after reset.
- R8: Squash makes every speculatively written line invalid and clears every speculation bit, so a later load of such an address returns the backing word. Lines that were only read speculatively stay valid.
- R9: Commit clears every speculation bit. Lines that were speculatively written become dirty valid lines, and they are written back when they are later evicted.
- R10: A request that misses on a line whose victim has either speculation bit set is not performed. overflow is high in that cycle, no response or broadcast follows, and the victim stays resident.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Processor request present |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqAddr | input | ADDR_W | Word/line address of the request |
| reqWdata | input | LINE_W | Store data |
| specMode | input | 1 | Request is performed speculatively |
| myEpoch | input | EPOCH_W | Epoch of the local thread |
| fillData | input | LINE_W | Backing word for reqAddr, used on a miss |
| respValid | output | 1 | Load data valid (cycle after request) |
| respData | output | LINE_W | Load data |
| overflow | output | 1 | Request refused: victim holds speculative state |
| wbValid | output | 1 | Write a word back to the backing store |
| wbAddr | output | ADDR_W | Write-back address |
| wbData | output | LINE_W | Write-back data |
| bcastValid | output | 1 | Speculative store broadcast valid |
| bcastAddr | output | ADDR_W | Broadcast store address |
| bcastEpoch | output | EPOCH_W | Epoch of the broadcasting thread |
| invValid | input | 1 | Incoming invalidation |
| invAddr | input | ADDR_W | Invalidated address |
| invEpoch | input | EPOCH_W | Epoch of the producer behind the invalidation |
| commit | input | 1 | Speculation succeeded |
| squash | input | 1 | Speculation failed: discard speculative state |
| violation | output | 1 | Sticky dependence-violation flag |

## Verification
The bench builds the cache with 4 lines, a 6-bit address, 32-bit words and 4-bit epochs. With so few lines, addresses four apart collide, and a handful of requests reach dirty evictions, refused misses on pinned victims and write-backs of committed speculative lines. The 4-bit epoch keeps lower, equal and higher invalidation epochs all easy to produce. A random phase over 16 addresses mixes loads, stores, invalidations, commits and squashes against a behavioural model.

// File: rtl/spec_cache_pkg.sv
package spec_cache_pkg;

  // Per-cycle strobes from the control to the line storage.
  typedef struct packed {
    logic fill;       // load the indexed line from fillData
    logic write;      // write store data into the indexed line
    logic setSl;      // mark indexed line speculatively read
    logic setSm;      // mark indexed line speculatively written
    logic markDirty;  // plain store: line becomes dirty
    logic cleanLine;  // old dirty word written back: clear dirty
    logic inval;      // coherence invalidation of the snooped line
    logic commit;     // flash: speculation bits clear, SM lines dirty
    logic squash;     // flash: SM lines dropped, bits clear
  } cacheStrobes_t;

endpackage

// File: rtl/spec_cache_dp.sv
module spec_cache_dp
  import spec_cache_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int LINE_W = 32,
  parameter int ADDR_W = 10,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  cacheStrobes_t     strb,
  input  logic [IDX_W-1:0]  reqIdx,
  input  logic [TAG_W-1:0]  reqTag,
  input  logic [LINE_W-1:0] wrData,
  input  logic [LINE_W-1:0] fillData,
  input  logic [IDX_W-1:0]  invIdx,
  input  logic [TAG_W-1:0]  invTag,
  output logic              lineValid,
  output logic              lineDirty,
  output logic              lineSl,
  output logic              lineSm,
  output logic [TAG_W-1:0]  lineTag,
  output logic [LINE_W-1:0] lineData,
  output logic              invMatch,
  output logic              invSl
);

  logic [LINES-1:0]  validQ, dirtyQ, slQ, smQ;
  logic [TAG_W-1:0]  tagQ  [LINES];
  logic [LINE_W-1:0] dataQ [LINES];

  // State bits: per-line updates first, flash operations last.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
      dirtyQ <= '0;
      slQ    <= '0;
      smQ    <= '0;
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (IDX_W'(i) == reqIdx) begin
          if (strb.fill) begin
            validQ[i] <= 1'b1;
            dirtyQ[i] <= 1'b0;
            slQ[i]    <= 1'b0;
            smQ[i]    <= 1'b0;
          end
          if (strb.setSl)     slQ[i]    <= 1'b1;
          if (strb.setSm)     smQ[i]    <= 1'b1;
          if (strb.markDirty) dirtyQ[i] <= 1'b1;
          if (strb.cleanLine) dirtyQ[i] <= 1'b0;
        end
        if (strb.inval && IDX_W'(i) == invIdx) begin
          validQ[i] <= 1'b0;
          dirtyQ[i] <= 1'b0;
          slQ[i]    <= 1'b0;
          smQ[i]    <= 1'b0;
        end
      end
      if (strb.commit) begin
        dirtyQ <= dirtyQ | smQ;
        slQ    <= '0;
        smQ    <= '0;
      end
      if (strb.squash) begin
        validQ <= validQ & ~smQ;
        dirtyQ <= dirtyQ & ~smQ;
        slQ    <= '0;
        smQ    <= '0;
      end
    end
  end

  // Tag and data arrays need no reset; valid guards them.
  always_ff @(posedge clk) begin
    if (strb.fill) tagQ[reqIdx] <= reqTag;
    if (strb.fill || strb.write)
      dataQ[reqIdx] <= strb.write ? wrData : fillData;
  end

  assign lineValid = validQ[reqIdx];
  assign lineDirty = dirtyQ[reqIdx];
  assign lineSl    = slQ[reqIdx];
  assign lineSm    = smQ[reqIdx];
  assign lineTag   = tagQ[reqIdx];
  assign lineData  = dataQ[reqIdx];
  assign invMatch  = validQ[invIdx] && (tagQ[invIdx] == invTag);
  assign invSl     = slQ[invIdx];

  AST_SQUASH_FLASH: assert property (@(posedge clk) disable iff (!rstN)
    strb.squash |=> (slQ == '0 && smQ == '0 && (validQ & $past(smQ)) == '0)); // R8
  AST_COMMIT_FLASH: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && !strb.inval && !strb.squash) |=>
      (slQ == '0 && smQ == '0 && (dirtyQ & $past(smQ)) == $past(smQ))); // R9
  AST_SPEC_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    ((slQ | smQ) & ~validQ) == '0); // R8

endmodule

// File: rtl/spec_cache_ctrl.sv
module spec_cache_ctrl
  import spec_cache_pkg::*;
#(
  parameter int LINES   = 8,
  parameter int LINE_W  = 32,
  parameter int ADDR_W  = 10,
  parameter int EPOCH_W = 8,
  localparam int IDX_W  = $clog2(LINES),
  localparam int TAG_W  = ADDR_W - IDX_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic               specMode,
  input  logic [EPOCH_W-1:0] myEpoch,
  input  logic [LINE_W-1:0]  fillData,
  input  logic               invValid,
  input  logic [EPOCH_W-1:0] invEpoch,
  input  logic               commit,
  input  logic               squash,
  input  logic               lineValid,
  input  logic               lineDirty,
  input  logic               lineSl,
  input  logic               lineSm,
  input  logic [TAG_W-1:0]   lineTag,
  input  logic [LINE_W-1:0]  lineData,
  input  logic               invMatch,
  input  logic               invSl,
  output cacheStrobes_t      strb,
  output logic               overflow,
  output logic               wbValid,
  output logic [ADDR_W-1:0]  wbAddr,
  output logic [LINE_W-1:0]  wbData,
  output logic               respValid,
  output logic [LINE_W-1:0]  respData,
  output logic               bcastValid,
  output logic [ADDR_W-1:0]  bcastAddr,
  output logic [EPOCH_W-1:0] bcastEpoch,
  output logic               violation
);

  logic hit, pinned, accept, miss, specStore, olderHit;

  assign hit       = lineValid && (lineTag == reqAddr[ADDR_W-1:IDX_W]);
  assign pinned    = lineValid && (lineSl || lineSm);
  assign overflow  = reqValid && !hit && pinned;
  assign accept    = reqValid && !overflow;
  assign miss      = accept && !hit;
  assign specStore = accept && reqWrite && specMode;
  assign olderHit  = invValid && invMatch && invSl && (invEpoch < myEpoch);

  always_comb begin
    strb           = '0;
    strb.fill      = miss;
    strb.write     = accept && reqWrite;
    strb.setSl     = accept && !reqWrite && specMode;
    strb.setSm     = specStore;
    strb.markDirty = accept && reqWrite && !specMode;
    strb.cleanLine = specStore && hit && lineDirty && !lineSm;
    strb.inval     = invValid && invMatch;
    strb.commit    = commit;
    strb.squash    = squash;
  end

  // Write-back: dirty victim on a miss, or committed word under a first speculative store.
  assign wbValid = (miss && lineValid && lineDirty) || strb.cleanLine;
  assign wbAddr  = {lineTag, reqAddr[IDX_W-1:0]};
  assign wbData  = lineData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid  <= 1'b0;
      respData   <= '0;
      bcastValid <= 1'b0;
      bcastAddr  <= '0;
      bcastEpoch <= '0;
      violation  <= 1'b0;
    end else begin
      respValid  <= accept && !reqWrite;
      if (accept && !reqWrite) respData <= hit ? lineData : fillData;
      bcastValid <= specStore;
      if (specStore) begin
        bcastAddr  <= reqAddr;
        bcastEpoch <= myEpoch;
      end
      violation  <= squash ? 1'b0 : (violation || olderHit);
    end
  end

  AST_BCAST_SPEC_STORE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && specMode && !overflow) |=>
      (bcastValid && bcastAddr == $past(reqAddr) && bcastEpoch == $past(myEpoch))); // R4
  AST_NO_PLAIN_BCAST: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqWrite && specMode) |=> !bcastValid); // R4
  AST_VIOL_FROM_OLDER: assert property (@(posedge clk) disable iff (!rstN)
    $rose(violation) |-> $past(invValid && (invEpoch < myEpoch))); // R6
  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (violation && !squash) |=> violation); // R7
  AST_SQUASH_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    squash |=> !violation); // R7
  AST_NO_OVERFLOW_RESP: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> (!respValid && !bcastValid)); // R10
  AST_NO_SPEC_WB: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> !lineSm); // R3

endmodule

// File: rtl/spec_cache.sv
module spec_cache
  import spec_cache_pkg::*;
#(
  parameter int LINES   = 8,
  parameter int LINE_W  = 32,
  parameter int ADDR_W  = 10,
  parameter int EPOCH_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [LINE_W-1:0]  reqWdata,
  input  logic               specMode,
  input  logic [EPOCH_W-1:0] myEpoch,
  input  logic [LINE_W-1:0]  fillData,
  output logic               respValid,
  output logic [LINE_W-1:0]  respData,
  output logic               overflow,
  output logic               wbValid,
  output logic [ADDR_W-1:0]  wbAddr,
  output logic [LINE_W-1:0]  wbData,
  output logic               bcastValid,
  output logic [ADDR_W-1:0]  bcastAddr,
  output logic [EPOCH_W-1:0] bcastEpoch,
  input  logic               invValid,
  input  logic [ADDR_W-1:0]  invAddr,
  input  logic [EPOCH_W-1:0] invEpoch,
  input  logic               commit,
  input  logic               squash,
  output logic               violation
);

  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  cacheStrobes_t     strb;
  logic              lineValid, lineDirty, lineSl, lineSm, invMatch, invSl;
  logic [TAG_W-1:0]  lineTag;
  logic [LINE_W-1:0] lineData;

  spec_cache_ctrl #(
    .LINES(LINES), .LINE_W(LINE_W), .ADDR_W(ADDR_W), .EPOCH_W(EPOCH_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .specMode(specMode), .myEpoch(myEpoch), .fillData(fillData),
    .invValid(invValid), .invEpoch(invEpoch),
    .commit(commit), .squash(squash),
    .lineValid(lineValid), .lineDirty(lineDirty), .lineSl(lineSl), .lineSm(lineSm),
    .lineTag(lineTag), .lineData(lineData), .invMatch(invMatch), .invSl(invSl),
    .strb(strb), .overflow(overflow),
    .wbValid(wbValid), .wbAddr(wbAddr), .wbData(wbData),
    .respValid(respValid), .respData(respData),
    .bcastValid(bcastValid), .bcastAddr(bcastAddr), .bcastEpoch(bcastEpoch),
    .violation(violation)
  );

  spec_cache_dp #(
    .LINES(LINES), .LINE_W(LINE_W), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .reqIdx(reqAddr[IDX_W-1:0]), .reqTag(reqAddr[ADDR_W-1:IDX_W]),
    .wrData(reqWdata), .fillData(fillData),
    .invIdx(invAddr[IDX_W-1:0]), .invTag(invAddr[ADDR_W-1:IDX_W]),
    .lineValid(lineValid), .lineDirty(lineDirty), .lineSl(lineSl), .lineSm(lineSm),
    .lineTag(lineTag), .lineData(lineData), .invMatch(invMatch), .invSl(invSl)
  );

endmodule

// File: tb/spec_cache_bench.sv
`timescale 1ns/1ps
module spec_cache_bench;

  localparam int LN = 4;
  localparam int LW = 32;
  localparam int AW = 6;
  localparam int EW = 4;
  localparam int NA = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 0, reqWrite = 0, specMode = 0;
  logic [AW-1:0] reqAddr = '0, invAddr = '0;
  logic [LW-1:0] reqWdata = '0;
  logic [EW-1:0] myEpoch = 4'd5, invEpoch = '0;
  logic invValid = 0, commit = 0, squash = 0;
  logic [LW-1:0] fillData;
  logic respValid, overflow, wbValid, bcastValid, violation;
  logic [LW-1:0] respData, wbData;
  logic [AW-1:0] wbAddr, bcastAddr;
  logic [EW-1:0] bcastEpoch;

  always #2.5 clk = ~clk;

  // Backing store and behavioural model, keyed by full address.
  logic [LW-1:0] mem [NA];
  logic [LW-1:0] mdat [NA];
  bit mv [NA], mdy [NA], msl [NA], msm [NA];
  bit mViol;
  int nChecks = 0, nErr = 0;
  string curReq = "R1";

  assign fillData = mem[reqAddr];

  spec_cache #(.LINES(LN), .LINE_W(LW), .ADDR_W(AW), .EPOCH_W(EW)) u_spec_cache (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .specMode(specMode), .myEpoch(myEpoch),
    .fillData(fillData), .respValid(respValid), .respData(respData),
    .overflow(overflow), .wbValid(wbValid), .wbAddr(wbAddr), .wbData(wbData),
    .bcastValid(bcastValid), .bcastAddr(bcastAddr), .bcastEpoch(bcastEpoch),
    .invValid(invValid), .invAddr(invAddr), .invEpoch(invEpoch),
    .commit(commit), .squash(squash), .violation(violation)
  );

  task automatic chk(bit ok, string what, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual %0h expected %0h", curReq, what, act, exp);
    end
  endtask

  task automatic idle();
    reqValid = 0; reqWrite = 0; specMode = 0; invValid = 0; commit = 0; squash = 0;
  endtask

  // One clock of stimulus already applied: check combinational outputs,
  // advance the model at the edge, check registered outputs afterwards.
  task automatic cycle();
    int set, vic, wbA, ra, ia;
    bit hit, pin, ovf, acc, wb, newV, eResp, eBc;
    logic [LW-1:0] wbD, eRespD;
    #1;
    ra = int'(reqAddr); ia = int'(invAddr);
    set = ra % LN; hit = mv[ra]; vic = -1;
    for (int a = 0; a < NA; a++) if (mv[a] && (a % LN) == set && a != ra) vic = a;
    pin = (vic >= 0) && (msl[vic] || msm[vic]);
    ovf = reqValid && !hit && pin;
    acc = reqValid && !ovf;
    wb = 0; wbA = 0; wbD = '0;
    if (acc && !hit && vic >= 0 && mdy[vic]) begin
      wb = 1; wbA = vic; wbD = mdat[vic];
    end else if (acc && reqWrite && specMode && hit && mdy[ra] && !msm[ra]) begin
      wb = 1; wbA = ra; wbD = mdat[ra];
    end
    chk(overflow === ovf, "overflow", 64'(overflow), 64'(ovf));
    chk(wbValid === wb, "wbValid", 64'(wbValid), 64'(wb));
    if (wb) begin
      chk(int'(wbAddr) == wbA, "wbAddr", 64'(wbAddr), 64'(wbA));
      chk(wbData === wbD, "wbData", 64'(wbData), 64'(wbD));
    end
    newV = invValid && mv[ia] && msl[ia] && (invEpoch < myEpoch);
    @(posedge clk);
    if (wb) mem[wbA] = wbD;
    eResp = 0; eRespD = '0; eBc = 0;
    if (acc) begin
      if (!hit) begin
        if (vic >= 0) begin mv[vic] = 0; mdy[vic] = 0; msl[vic] = 0; msm[vic] = 0; end
        mv[ra] = 1; mdat[ra] = mem[ra]; mdy[ra] = 0; msl[ra] = 0; msm[ra] = 0;
      end
      if (!reqWrite) begin
        eResp = 1; eRespD = mdat[ra];
        if (specMode) msl[ra] = 1;
      end else begin
        mdat[ra] = reqWdata;
        if (specMode) begin msm[ra] = 1; mdy[ra] = 0; eBc = 1; end
        else mdy[ra] = 1;
      end
    end
    if (invValid && mv[ia]) begin mv[ia] = 0; mdy[ia] = 0; msl[ia] = 0; msm[ia] = 0; end
    if (commit) for (int a = 0; a < NA; a++) begin
      if (msm[a]) mdy[a] = 1;
      msl[a] = 0; msm[a] = 0;
    end
    if (squash) for (int a = 0; a < NA; a++) begin
      if (msm[a]) begin mv[a] = 0; mdy[a] = 0; end
      msl[a] = 0; msm[a] = 0;
    end
    mViol = squash ? 1'b0 : (mViol || newV);
    @(negedge clk);
    chk(respValid === eResp, "respValid", 64'(respValid), 64'(eResp));
    if (eResp) chk(respData === eRespD, "respData", 64'(respData), 64'(eRespD));
    chk(bcastValid === eBc, "bcastValid", 64'(bcastValid), 64'(eBc));
    if (eBc) begin
      chk(int'(bcastAddr) == ra, "bcastAddr", 64'(bcastAddr), 64'(ra));
      chk(bcastEpoch === myEpoch, "bcastEpoch", 64'(bcastEpoch), 64'(myEpoch));
    end
    chk(violation === mViol, "violation", 64'(violation), 64'(mViol));
    idle();
  endtask

  task automatic ld(int a, bit spec);
    reqValid = 1; reqWrite = 0; reqAddr = AW'(a); specMode = spec; cycle();
  endtask
  task automatic st(int a, logic [LW-1:0] d, bit spec);
    reqValid = 1; reqWrite = 1; reqAddr = AW'(a); reqWdata = d; specMode = spec; cycle();
  endtask
  task automatic snoop(int a, int ep);
    invValid = 1; invAddr = AW'(a); invEpoch = EW'(ep); cycle();
  endtask
  task automatic doCommit(); commit = 1; cycle(); endtask
  task automatic doSquash(); squash = 1; cycle(); endtask
  task automatic nop(); cycle(); endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  initial begin
    #200000;
    nErr++;
    nChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    for (int a = 0; a < NA; a++) begin
      mem[a] = 32'h1000_0000 + 32'(a) * 32'h0001_0203;
      mdat[a] = '0; mv[a] = 0; mdy[a] = 0; msl[a] = 0; msm[a] = 0;
    end
    mViol = 0;
    repeat (3) @(negedge clk);
    curReq = "R7";
    chk(violation === 1'b0, "reset violation", 64'(violation), 64'd0);
    chk(respValid === 1'b0, "reset respValid", 64'(respValid), 64'd0);
    chk(bcastValid === 1'b0, "reset bcastValid", 64'(bcastValid), 64'd0);
    rstN = 1;
    @(negedge clk);

    curReq = "R1";  ld(1, 0); ld(1, 0); ld(2, 0);
    curReq = "R2";  st(1, 32'hAAAA_0001, 0); ld(5, 0); ld(1, 0);
    curReq = "R4";  st(6, 32'h0000_0066, 0);
    curReq = "R5";  ld(2, 1);
    curReq = "R3";  st(3, 32'h5555_0003, 1);
    curReq = "R10"; ld(6, 1); st(7, 32'h77, 1); ld(2, 0); ld(3, 0);
    curReq = "R6";  snoop(2, 7); ld(2, 1); snoop(2, 5); ld(2, 1); snoop(11, 1);
    curReq = "R5";  snoop(2, 4);
    curReq = "R7";  nop(); nop(); ld(3, 0);
    curReq = "R8";  ld(13, 1); doSquash(); nop(); ld(3, 0); ld(13, 0);
    curReq = "R3";  st(4, 32'hD00D_0004, 0); st(4, 32'hBEEF_0004, 1); st(9, 32'h9999_0009, 1);
    curReq = "R9";  doCommit(); ld(8, 0); ld(5, 0); ld(4, 0);

    curReq = "R6";
    for (int n = 0; n < 600; n++) begin
      int op;
      op = $urandom_range(0, 11);
      myEpoch = EW'($urandom_range(3, 8));
      if (op <= 6) begin
        if ($urandom_range(0, 1) == 1) st($urandom_range(0, 15), 32'($urandom), $urandom_range(0, 1) == 1);
        else ld($urandom_range(0, 15), $urandom_range(0, 1) == 1);
      end else if (op <= 9) snoop($urandom_range(0, 15), $urandom_range(0, 15));
      else if (op == 10) doCommit();
      else doSquash();
    end
    finishRun();
  end

endmodule